// File: doc/BRIEF.md
# ADC Conversion Power-Mode Controller

This block sequences one conversion of a 12-bit successive-approximation converter. It also decides what happens to that conversion when the module is disabled, when the processor sleeps or idles, and when reset arrives. The analog converter is replaced by a fixed-length counter. When the count finishes, the value on the stub data input is captured into the result buffer.

Two conversion clocks are modelled by a select input. With the system clock selected, sleep stops the converter clock, so a running conversion is abandoned. With the always-on RC clock selected, the conversion keeps running through sleep. Each accepted start then waits one extra cycle before counting begins. A conversion that finishes during sleep does one of two things. With the interrupt enabled it raises a wake request. With the interrupt disabled it parks the module in a powered-down state, and the enable input stays high throughout.

An idle-stop option selects what idle does: with it clear, idle has no effect; with it set, the sequence freezes for as long as idle is high. Reset returns the controller to its ready state and aborts any conversion, but leaves the result buffer unchanged.

Top module: `adc_pwr_seq`

## Requirements
- R1: With `enable` low the module is off: `busy` is low one cycle later, a running conversion is dropped and `start` is ignored.
- R2: With `rc_sel`=0, `sleep` high during a conversion aborts it on the next edge (`busy` falls, `result` unchanged, no `done_irq`). The conversion does not resume when sleep ends.
- R3: Raising and lowering `sleep` while no conversion runs leaves `result` unchanged.
- R4: An accepted `start` raises `busy` on the next edge. `busy` then stays high for 14 cycles with `rc_sel`=0, or 15 cycles with `rc_sel`=1 (the one-cycle start delay), plus one cycle for every edge frozen by R9.
- R5: On the edge that completes a conversion, `busy` falls and `result` takes the value of `conv_data` at that edge. `done_irq` pulses for exactly one cycle if `irq_en`=1 and stays low if `irq_en`=0.
- R6: A conversion that completes with `sleep`=1 and `irq_en`=1 also pulses `wake_req` for one cycle. `wake_req` never pulses otherwise.
- R7: A conversion that completes with `sleep`=1 and `irq_en`=0 powers the module down: no `done_irq` and no `wake_req` pulse, and every later `start` is ignored while `enable` stays 1.
- R8: The powered-down state is left only by driving `enable` low for at least one cycle or by reset. After that, a `start` is accepted again.
- R9: With `idle_stop`=0, `idle` has no effect. With `idle_stop`=1 and `idle`=1, the conversion holds its progress on every such edge and `busy` stays high.
- R10: A `start` while `busy` is high is ignored and does not change the conversion length.
- R11: Reset (`rst_n` low) clears `busy`, `done_irq` and `wake_req`, aborts any conversion and keeps `result` unchanged.
- R12: With `rc_sel`=0 and `sleep`=1, `start` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Module on (1) or off (0) |
| rc_sel | input | 1 | 1 selects the always-on RC clock, 0 the system clock |
| sleep | input | 1 | Processor sleep indication |
| idle | input | 1 | Processor idle indication |
| idle_stop | input | 1 | 1 freezes the conversion during idle |
| irq_en | input | 1 | Completion interrupt enable |
| start | input | 1 | Conversion start request |
| conv_data | input | DW | Stub converter output, captured on completion |
| busy | output | 1 | Conversion in progress |
| result | output | DW | Result buffer |
| done_irq | output | 1 | One-cycle completion interrupt |
| wake_req | output | 1 | One-cycle wake request to the processor |

## Verification
Two events can land on the same edge: completion of a conversion and a change of power condition. Completion can coincide with sleep, which decides between a normal finish, a wake request and power-down. A count step can coincide with an idle freeze, which decides whether the sequence advances. The bench runs random conversions that mix the clock select, interrupt enable, sleep and the idle-stop option, and it toggles idle at random on each busy cycle. For every run it predicts the busy length, the captured value and the interrupt and wake pulses. Directed cases then provoke an abort by sleep with the system clock, an abort by enable, power-down exit and reset during a conversion, and check that the result buffer survives each of them.

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq #(
  parameter int DW          = 12,
  parameter int CONV_CYCLES = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          rc_sel,
  input  logic          sleep,
  input  logic          idle,
  input  logic          idle_stop,
  input  logic          irq_en,
  input  logic          start,
  input  logic [DW-1:0] conv_data,
  output logic          busy,
  output logic [DW-1:0] result,
  output logic          done_irq,
  output logic          wake_req
);
  localparam int CW = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CONV_CYCLES - 1);

  typedef enum logic [1:0] {S_READY, S_DELAY, S_CONV, S_PDOWN} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          done_q, wake_q;

  wire halted    = idle & idle_stop;
  wire sys_sleep = sleep & ~rc_sel;
  wire accept    = enable & (st == S_READY) & start & ~halted & ~sys_sleep;
  wire complete  = enable & (st == S_CONV) & ~sys_sleep & ~halted & (cnt == LAST);

  assign busy     = (st == S_DELAY) | (st == S_CONV);
  assign done_irq = done_q;
  assign wake_req = wake_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_READY;
      cnt    <= '0;
      done_q <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      wake_q <= 1'b0;
      if (!enable) begin
        st  <= S_READY;
        cnt <= '0;
      end else begin
        unique case (st)
          S_READY: if (accept) begin
            st  <= rc_sel ? S_DELAY : S_CONV;
            cnt <= '0;
          end
          S_DELAY: begin
            if (sys_sleep)    st <= S_READY;
            else if (!halted) st <= S_CONV;
          end
          S_CONV: begin
            if (sys_sleep) st <= S_READY;
            else if (complete) begin
              st     <= (sleep && !irq_en) ? S_PDOWN : S_READY;
              done_q <= irq_en;
              wake_q <= irq_en & sleep;
            end else if (!halted) cnt <= cnt + 1'b1;
          end
          S_PDOWN: st <= S_PDOWN;
          default: st <= S_READY;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (complete) result <= conv_data;
  end

  assert_off_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !busy);

  assert_sleep_abort_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy && sys_sleep && enable |=> !busy && !done_irq && $stable(result));

  assert_wake_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> $past(sleep && irq_en && busy));

  assert_pdown_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PDOWN) && enable |=> !busy && !done_irq && !wake_req);

  assert_idle_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && halted && enable && !sys_sleep |=> busy);

  assert_restart_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && enable && !sys_sleep && !complete |=> busy);
endmodule

// File: tb/tb_adc_pwr_seq.sv
module tb_adc_pwr_seq;
  localparam int DW = 12;
  localparam int NC = 14;

  logic clk = 1'b0, rst_n = 1'b0;
  logic enable = 0, rc_sel = 0, sleep = 0, idle = 0, idle_stop = 0, irq_en = 0, start = 0;
  logic [DW-1:0] conv_data = '0;
  logic busy, done_irq, wake_req;
  logic [DW-1:0] result;

  int total = 0, bad = 0;

  adc_pwr_seq #(.DW(DW), .CONV_CYCLES(NC)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .rc_sel(rc_sel), .sleep(sleep),
    .idle(idle), .idle_stop(idle_stop), .irq_en(irq_en), .start(start),
    .conv_data(conv_data), .busy(busy), .result(result),
    .done_irq(done_irq), .wake_req(wake_req));

  always #4 clk = ~clk;

  function automatic int exp_len(input bit rc, input int halts);
    return NC + (rc ? 1 : 0) + halts;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_conv(input bit rc, input bit ie, input bit slp, input bit ist,
                          input bit rnd_idle, input logic [DW-1:0] d,
                          output int n, output int halts);
    rc_sel = rc; irq_en = ie; sleep = slp; idle_stop = ist; idle = 0;
    conv_data = d; start = 1;
    @(negedge clk);
    start = 0; n = 0; halts = 0;
    while (busy && n < 200) begin
      n++;
      idle = rnd_idle && ($urandom % 4 == 0);
      if (idle && ist) halts++;
      @(negedge clk);
    end
    idle = 0;
  endtask

  task automatic try_start(output bit got);
    start = 1;
    @(negedge clk);
    start = 0;
    got = busy;
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n, h;
    bit got;
    logic [DW-1:0] keep;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!busy && !done_irq && !wake_req, "R11 reset state", busy, 0);
    rst_n = 1;
    @(negedge clk);

    // R1: start ignored while off
    try_start(got);
    chk(!got, "R1 start while off", got, 0);
    enable = 1;
    @(negedge clk);

    // R4/R5 directed, system clock
    run_conv(0, 1, 0, 0, 0, 12'hA5C, n, h);
    chk(n == exp_len(0, 0), "R4 length sysclk", n, exp_len(0, 0));
    chk(result == 12'hA5C, "R5 result", result, 12'hA5C);
    chk(done_irq == 1, "R5 done pulse", done_irq, 1);
    chk(wake_req == 0, "R6 no wake awake", wake_req, 0);
    @(negedge clk);
    chk(done_irq == 0, "R5 pulse one cycle", done_irq, 0);

    // R4 RC clock
    run_conv(1, 0, 0, 0, 0, 12'h3F1, n, h);
    chk(n == exp_len(1, 0), "R4 length rc", n, exp_len(1, 0));
    chk(result == 12'h3F1 && done_irq == 0, "R5 no irq when disabled", done_irq, 0);

    // R10 start while busy
    rc_sel = 0; irq_en = 1; conv_data = 12'h0B7; start = 1;
    @(negedge clk);
    n = 0;
    while (busy && n < 200) begin n++; start = (n == 5); @(negedge clk); end
    start = 0;
    chk(n == exp_len(0, 0), "R10 restart ignored", n, exp_len(0, 0));
    @(negedge clk);
    chk(!busy, "R10 no second conversion", busy, 0);

    // R2 sleep abort with system clock
    keep = result;
    rc_sel = 0; conv_data = 12'hFFF; start = 1;
    @(negedge clk);
    start = 0;
    repeat (4) @(negedge clk);
    sleep = 1;
    @(negedge clk);
    chk(!busy, "R2 abort busy", busy, 0);
    sleep = 0;
    n = 0;
    repeat (20) begin @(negedge clk); if (busy || done_irq) n++; end
    chk(n == 0, "R2 not resumed", n, 0);
    chk(result == keep, "R2 result kept", result, keep);

    // R12 start during system-clock sleep
    sleep = 1;
    try_start(got);
    chk(!got, "R12 start in sleep ignored", got, 0);
    sleep = 0;
    // R3 sleep without conversion
    repeat (3) @(negedge clk);
    chk(result == keep, "R3 sleep leaves result", result, keep);

    // R1 abort by enable
    rc_sel = 0; start = 1;
    @(negedge clk);
    start = 0;
    repeat (3) @(negedge clk);
    enable = 0;
    @(negedge clk);
    chk(!busy && result == keep, "R1 enable abort", busy, 0);
    enable = 1;
    @(negedge clk);

    // R6 wake
    run_conv(1, 1, 1, 0, 0, 12'h5A5, n, h);
    chk(wake_req == 1 && done_irq == 1, "R6 wake pulse", wake_req, 1);
    chk(result == 12'h5A5, "R6 result in sleep", result, 12'h5A5);
    @(negedge clk);
    chk(wake_req == 0, "R6 wake one cycle", wake_req, 0);

    // R7 power-down and R8 exit
    run_conv(1, 0, 1, 0, 0, 12'h246, n, h);
    chk(n == exp_len(1, 0) && result == 12'h246, "R7 completes in sleep", result, 12'h246);
    chk(!wake_req && !done_irq, "R7 no pulses", wake_req, 0);
    sleep = 0;
    try_start(got);
    chk(!got, "R7 start ignored in pdown", got, 0);
    enable = 0; @(negedge clk); enable = 1; @(negedge clk);
    try_start(got);
    chk(got, "R8 exit by enable toggle", got, 1);
    repeat (20) @(negedge clk);
    run_conv(1, 0, 1, 0, 0, 12'h135, n, h);
    sleep = 0;
    rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
    try_start(got);
    chk(got, "R8 exit by reset", got, 1);
    repeat (20) @(negedge clk);

    // R9 directed idle
    rc_sel = 0; irq_en = 0; idle_stop = 0; idle = 1; conv_data = 12'h777; start = 1;
    @(negedge clk);
    start = 0; n = 0;
    while (busy && n < 200) begin n++; @(negedge clk); end
    idle = 0;
    chk(n == exp_len(0, 0), "R9 idle ignored", n, exp_len(0, 0));

    // R11 reset during conversion
    keep = result;
    conv_data = 12'h000; start = 1;
    @(negedge clk);
    start = 0;
    repeat (5) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk(!busy && result == keep, "R11 reset abort", result, keep);
    rst_n = 1;
    repeat (20) @(negedge clk);
    chk(!busy && result == keep, "R11 no resume", result, keep);

    // random mix
    for (int i = 0; i < 40; i++) begin
      bit rc, ie, slp, ist;
      logic [DW-1:0] d;
      rc = $urandom % 2; ie = $urandom % 2; ist = $urandom % 2;
      slp = rc ? ($urandom % 2) : 1'b0;
      d = DW'($urandom);
      run_conv(rc, ie, slp, ist, 1, d, n, h);
      chk(n == exp_len(rc, h), "R4 R9 random length", n, exp_len(rc, h));
      chk(result == d, "R5 random result", result, d);
      chk(done_irq == ie, "R5 random irq", done_irq, ie);
      chk(wake_req == (ie && slp), "R6 random wake", wake_req, ie && slp);
      sleep = 0;
      if (slp && !ie) begin
        try_start(got);
        chk(!got, "R7 random pdown", got, 0);
        enable = 0; @(negedge clk); enable = 1;
      end
      @(negedge clk);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule